// File: doc/BRIEF.md
# Maskable Interrupt Sequencer with Vectoring

This block is the interrupt controller of a small 8-bit processor core. Each source has a pending bit and an enable bit, and one global enable gates them all. Source inputs are asynchronous. Each one passes through a synchroniser, and a rising edge sets its pending bit. The bit stays set until software clears it or reset arrives. A source is *active* when its pending bit and its enable bit are both set.

At each instruction boundary the block looks for an active source. It takes one only if the global enable is set, the boundary is not a skipped instruction, and the boot-ROM mode input is low. When it takes a source it runs a fixed acknowledge sequence:

- The global enable is cleared.
- The address of the instruction about to run is pushed to the stack.
- The program counter is loaded with the common service address 0x00FF on the last acknowledge cycle.

A return request pops the saved address, loads it into the program counter, and sets the global enable again. A vector-select request returns the index of the highest-priority active source, for an indirect jump through a vector table.

Stack traffic uses two valid/ready streams:

- **Push stream.** The block is the producer. While `push_valid_o` is high and `push_ready_i` is low, the sequence stalls and `push_data_o` holds its value.
- **Pop stream.** The stack is the producer. The block raises `pop_ready_o` while it waits for a return. A word is consumed on a cycle where `pop_valid_i` and `pop_ready_o` are both high.

All other pins are plain control and status.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the pending bits, enable bits and global enable are all zero, and `busy_o`, `push_valid_o`, `pop_ready_o`, `pc_load_o` and `vis_done_o` are low.
- R2: A rising edge on `src_i[k]` that is set up before clock edge e0 makes `pend_o[k]` read 1 after edge e2. A pending bit falls only through a write with select 0 and a 0 in that bit position; a 1 in the written value leaves the bit unchanged. A rising edge in the same cycle as a clearing write leaves the bit set.
- R3: An acknowledge starts on the edge where all of the following hold: `insn_start_i` is high, `skip_i` is low, `boot_mode_i` is low, the global enable is 1, at least one source is active, and the block is not busy. With no active source, or with the global enable at 0, a boundary starts nothing.
- R4: On the edge that starts an acknowledge, the global enable goes to 0 and `cur_pc_i` is captured. In acknowledge cycle 1, `push_valid_o` offers that address and holds it until `push_ready_i` accepts it. `pc_load_o` pulses with address 0x00FF in acknowledge cycle 7. One done cycle follows. `busy_o` stays high from cycle 1 through the done cycle.
- R5: A boundary marked with `skip_i` high never starts an acknowledge. The source remains pending and is taken at the next boundary that is not skipped.
- R6: When `reti_i` is high while the block is idle, `pop_ready_o` rises and stays high until a pop handshake. On the handshake cycle `pc_load_o` is high with `pc_load_addr_o` equal to `pop_data_i`, and the global enable becomes 1 on that edge. A source that is still active is then taken at the next boundary.
- R7: A pending bit that is already set is taken at the next boundary once its enable bit is written to 1 with the global enable set.
- R8: While `boot_mode_i` is high, no acknowledge starts and the global enable keeps its value. Repeat edges on a source that is already pending are lost. Once the mode drops, the next boundary acknowledges if the global enable is set.
- R9: One cycle after `vis_req_i`, `vis_done_o` pulses and `vis_hit_o` reports whether any source was active. `vis_idx_o` gives the lowest active index (index 0 has the highest priority), or 0 when nothing is active.
- R10: A register write (`reg_wr_i`) uses `reg_sel_i` as follows:
  - 0: pending (clear mask)
  - 1: enable (written as given)
  - 2: global enable (taken from `reg_wdata_i[0]`)
  - 3: no effect on any register

  The acknowledge clear of the global enable takes priority over the return set, and the return set takes priority over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Asynchronous source event lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 pending, 1 enable, 2 global enable, 3 none) |
| reg_wdata_i | input | NSRC | Register write value |
| pend_o | output | NSRC | Pending bits |
| en_o | output | NSRC | Enable bits |
| gie_o | output | 1 | Global interrupt enable |
| insn_start_i | input | 1 | Instruction boundary strobe |
| skip_i | input | 1 | Instruction at this boundary is skipped |
| cur_pc_i | input | AW | Address of the instruction about to run |
| boot_mode_i | input | 1 | Boot-ROM execution, suppresses acknowledge |
| reti_i | input | 1 | Return-from-interrupt request |
| vis_req_i | input | 1 | Vector-select request |
| vis_done_o | output | 1 | Vector-select result strobe |
| vis_hit_o | output | 1 | An active source was found |
| vis_idx_o | output | IDXW | Index of the highest-priority active source |
| push_valid_o | output | 1 | Stack push valid |
| push_ready_i | input | 1 | Stack push ready |
| push_data_o | output | AW | Return address to push |
| pop_valid_i | input | 1 | Stack pop valid |
| pop_ready_o | output | 1 | Block ready to take the popped address |
| pop_data_i | input | AW | Popped return address |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_load_addr_o | output | AW | Program counter load value |
| busy_o | output | 1 | Acknowledge or return in progress |

## Verification
The bench attacks the following corner cases:

- **Set and clear in the same cycle.** A source edge lands on the same cycle as a clearing write. A design that lets the write win would silently drop an event.
- **Skip and boot-mode boundaries.** The bench offers boundaries with skip set and boundaries during boot mode. A design that ignored either would jump to 0x00FF in the middle of a skipped instruction or inside boot code. A design that cleared the global enable in boot mode would never acknowledge again.
- **Stack back-pressure.** The push is held off for several cycles. A design that drops or changes the address under stall would return to the wrong place. A design that counts the seven cycles from the start rather than from the handshake would load the PC early.
- **Return and vectoring.** Returns with a delayed pop must not load the PC before the handshake, and must take a still-active source at the next boundary. Vector selects with masked pending sources expose an encoder with inverted priority or one that ignores the enable mask.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_EN   = 2'd1,
    SEL_GIE  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_DONE = 2'd2,
    ST_RET  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int NSRC   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] rise_o
);
  // per source: STAGES synchroniser flops plus one history flop
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], src_i[i]};
    end
    assign rise_o[i] = sh[STAGES-1] & ~sh[STAGES];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o
);
  // lowest index wins: scan downward so the last match is the smallest
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        hit_o = 1'b1;
        idx_o = IDXW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          ACK_LEN  = 7,
  parameter logic [AW-1:0] SVC_ADDR = 16'h00FF,
  localparam int         CNTW     = $clog2(ACK_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          push_ready_i,
  output logic          push_valid_o,
  output logic [AW-1:0] push_data_o,
  input  logic          pop_valid_i,
  output logic          pop_ready_o,
  input  logic [AW-1:0] pop_data_i,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_load_addr_o,
  output logic          busy_o,
  output logic          idle_o,
  output logic          ret_done_o
);
  seq_state_e      state_q;
  logic [CNTW-1:0] cnt_q;
  logic [AW-1:0]   addr_q;
  logic            last_ack;

  assign last_ack = (state_q == ST_ACK) && (cnt_q == CNTW'(ACK_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ACK;
            cnt_q   <= CNTW'(1);
            addr_q  <= ret_addr_i;
          end else if (ret_i) begin
            state_q <= ST_RET;
          end
        end
        ST_ACK: begin
          if (last_ack) begin
            state_q <= ST_DONE;
            cnt_q   <= '0;
          end else if (!(cnt_q == CNTW'(1) && !push_ready_i)) begin
            cnt_q <= cnt_q + CNTW'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        ST_RET:  if (pop_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign push_valid_o   = (state_q == ST_ACK) && (cnt_q == CNTW'(1));
  assign push_data_o    = addr_q;
  assign pop_ready_o    = (state_q == ST_RET);
  assign ret_done_o     = pop_ready_o && pop_valid_i;
  assign pc_load_o      = last_ack || ret_done_o;
  assign pc_load_addr_o = pop_ready_o ? pop_data_i : SVC_ADDR;
  assign busy_o         = (state_q != ST_IDLE);
  assign idle_o         = (state_q == ST_IDLE);

  initial assert (ACK_LEN >= 2) else $error("ACK_LEN must be at least 2");

  p_push_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o && !push_ready_i |=> push_valid_o && $stable(push_data_o));
  p_svc_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o && !pop_ready_o |-> pc_load_addr_o == SVC_ADDR);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && idle_o |=> busy_o && push_valid_o);
  p_pop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o && pop_ready_o |-> pop_valid_i && pc_load_addr_o == pop_data_i);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter int            NSRC        = 8,
  parameter int            AW          = 16,
  parameter int            ACK_LEN     = 7,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] SVC_ADDR    = 16'h00FF,
  localparam int           IDXW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [NSRC-1:0] reg_wdata_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o,
  output logic            gie_o,
  input  logic            insn_start_i,
  input  logic            skip_i,
  input  logic [AW-1:0]   cur_pc_i,
  input  logic            boot_mode_i,
  input  logic            reti_i,
  input  logic            vis_req_i,
  output logic            vis_done_o,
  output logic            vis_hit_o,
  output logic [IDXW-1:0] vis_idx_o,
  output logic            push_valid_o,
  input  logic            push_ready_i,
  output logic [AW-1:0]   push_data_o,
  input  logic            pop_valid_i,
  output logic            pop_ready_o,
  input  logic [AW-1:0]   pop_data_i,
  output logic            pc_load_o,
  output logic [AW-1:0]   pc_load_addr_o,
  output logic            busy_o
);
  logic [NSRC-1:0] pend_q, en_q, rise, active;
  logic            gie_q;
  logic            fsm_idle, ret_done, ack_start;
  logic            enc_hit;
  logic [IDXW-1:0] enc_idx;
  logic            vis_done_q, vis_hit_q;
  logic [IDXW-1:0] vis_idx_q;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_sel_i);

  irq_edge_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
  );

  assign active = pend_q & en_q;

  irq_prio_enc #(.N(NSRC)) u_enc (
    .req_i(active), .hit_o(enc_hit), .idx_o(enc_idx)
  );

  assign ack_start = fsm_idle && insn_start_i && !skip_i && !boot_mode_i
                     && gie_q && enc_hit;

  irq_ack_fsm #(.AW(AW), .ACK_LEN(ACK_LEN), .SVC_ADDR(SVC_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_i(ack_start), .ret_i(reti_i), .ret_addr_i(cur_pc_i),
    .push_ready_i(push_ready_i), .push_valid_o(push_valid_o), .push_data_o(push_data_o),
    .pop_valid_i(pop_valid_i), .pop_ready_o(pop_ready_o), .pop_data_i(pop_data_i),
    .pc_load_o(pc_load_o), .pc_load_addr_o(pc_load_addr_o),
    .busy_o(busy_o), .idle_o(fsm_idle), .ret_done_o(ret_done)
  );

  // pending: software can only clear, a fresh edge always wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (reg_wr_i && sel == SEL_PEND) pend_q <= (pend_q & reg_wdata_i) | rise;
    else pend_q <= pend_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (reg_wr_i && sel == SEL_EN) en_q <= reg_wdata_i;
  end

  // global enable: acknowledge clear > return set > software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gie_q <= 1'b0;
    else if (ack_start)                 gie_q <= 1'b0;
    else if (ret_done)                  gie_q <= 1'b1;
    else if (reg_wr_i && sel == SEL_GIE) gie_q <= reg_wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_done_q <= 1'b0;
      vis_hit_q  <= 1'b0;
      vis_idx_q  <= '0;
    end else begin
      vis_done_q <= vis_req_i;
      if (vis_req_i) begin
        vis_hit_q <= enc_hit;
        vis_idx_q <= enc_idx;
      end
    end
  end

  assign pend_o     = pend_q;
  assign en_o       = en_q;
  assign gie_o      = gie_q;
  assign vis_done_o = vis_done_q;
  assign vis_hit_o  = vis_hit_q;
  assign vis_idx_o  = vis_idx_q;

  p_gie_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |=> !gie_q && busy_o);
  p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && sel == SEL_PEND) |=> ($past(pend_q) & ~pend_q) == '0);
  p_boot_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_mode_i && !reg_wr_i && !ret_done |=> gie_q == $past(gie_q));
  p_vis_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vis_req_i |=> vis_done_o);
  p_vis_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vis_done_o && !vis_hit_o |-> vis_idx_o == '0);
  p_ret_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> gie_q);
endmodule

// File: tb/irq_sequencer_tb.sv
module irq_sequencer_tb;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic reg_wr_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd3;
  logic [N-1:0] reg_wdata_i = '0;
  logic [N-1:0] pend_o, en_o;
  logic gie_o;
  logic insn_start_i = 1'b0, skip_i = 1'b0, boot_mode_i = 1'b0, reti_i = 1'b0;
  logic [AW-1:0] cur_pc_i = '0;
  logic vis_req_i = 1'b0, vis_done_o, vis_hit_o;
  logic [IW-1:0] vis_idx_o;
  logic push_valid_o, push_ready_i = 1'b1;
  logic [AW-1:0] push_data_o;
  logic pop_valid_i = 1'b0, pop_ready_o;
  logic [AW-1:0] pop_data_i = '0;
  logic pc_load_o;
  logic [AW-1:0] pc_load_addr_o;
  logic busy_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .pend_o(pend_o), .en_o(en_o),
    .gie_o(gie_o), .insn_start_i(insn_start_i), .skip_i(skip_i), .cur_pc_i(cur_pc_i),
    .boot_mode_i(boot_mode_i), .reti_i(reti_i), .vis_req_i(vis_req_i),
    .vis_done_o(vis_done_o), .vis_hit_o(vis_hit_o), .vis_idx_o(vis_idx_o),
    .push_valid_o(push_valid_o), .push_ready_i(push_ready_i), .push_data_o(push_data_o),
    .pop_valid_i(pop_valid_i), .pop_ready_o(pop_ready_o), .pop_data_i(pop_data_i),
    .pc_load_o(pc_load_o), .pc_load_addr_o(pc_load_addr_o), .busy_o(busy_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] m_s1, m_s2, m_s3, m_pend, m_en;
  bit m_gie, m_ret, m_vd, m_vh;
  int m_phase;            // 0 idle, 1..7 acknowledge cycles, 8 done cycle
  int m_vi;
  logic [AW-1:0] m_addr;

  always @(posedge clk) begin : model
    logic [N-1:0] act, rise;
    bit acc, retgo, retdone;
    int lo;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_pend = '0; m_en = '0;
      m_gie = 0; m_ret = 0; m_vd = 0; m_vh = 0; m_phase = 0; m_vi = 0; m_addr = '0;
    end else begin
      act = m_pend & m_en;
      rise = m_s2 & ~m_s3;
      lo = -1;
      for (int k = 0; k < N; k++) if (act[k] && lo < 0) lo = k;
      acc = (m_phase == 0) && !m_ret && insn_start_i && !skip_i && !boot_mode_i
            && m_gie && (act != 0);
      retgo = (m_phase == 0) && !m_ret && !acc && reti_i;
      retdone = m_ret && pop_valid_i;
      if (acc) m_gie = 0;
      else if (retdone) m_gie = 1;
      else if (reg_wr_i && reg_sel_i == 2'd2) m_gie = reg_wdata_i[0];
      if (reg_wr_i && reg_sel_i == 2'd0) m_pend = m_pend & reg_wdata_i;
      m_pend = m_pend | rise;
      if (reg_wr_i && reg_sel_i == 2'd1) m_en = reg_wdata_i;
      m_vd = vis_req_i;
      if (vis_req_i) begin m_vh = (act != 0); m_vi = (lo < 0) ? 0 : lo; end
      if (acc) begin m_phase = 1; m_addr = cur_pc_i; end
      else if (m_phase == 1 && !push_ready_i) m_phase = 1;
      else if (m_phase == 8) m_phase = 0;
      else if (m_phase != 0) m_phase = m_phase + 1;
      if (retgo) m_ret = 1;
      else if (retdone) m_ret = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src_i;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 pend_o", 32'(pend_o), 32'(m_pend));
      chk("R10 en_o", 32'(en_o), 32'(m_en));
      chk("R4 gie_o", 32'(gie_o), 32'(m_gie));
      chk("R4 busy_o", 32'(busy_o), 32'(m_phase != 0 || m_ret));
      chk("R4 push_valid_o", 32'(push_valid_o), 32'(m_phase == 1));
      if (m_phase == 1) chk("R4 push_data_o", 32'(push_data_o), 32'(m_addr));
      chk("R6 pop_ready_o", 32'(pop_ready_o), 32'(m_ret));
      chk("R4 pc_load_o", 32'(pc_load_o), 32'(m_phase == 7 || (m_ret && pop_valid_i)));
      if (pc_load_o)
        chk("R6 pc_load_addr_o", 32'(pc_load_addr_o),
            (m_phase == 7) ? 32'h00FF : 32'(pop_data_i));
      chk("R9 vis_done_o", 32'(vis_done_o), 32'(m_vd));
      if (m_vd) begin
        chk("R9 vis_hit_o", 32'(vis_hit_o), 32'(m_vh));
        chk("R9 vis_idx_o", 32'(vis_idx_o), 32'(m_vi));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    step(1);
    reg_wr_i = 1'b0; reg_sel_i = 2'd3;
  endtask

  task automatic boundary(input logic skp, input logic [AW-1:0] pc);
    insn_start_i = 1'b1; skip_i = skp; cur_pc_i = pc;
    step(1);
    insn_start_i = 1'b0; skip_i = 1'b0;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      summary();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 en", 32'(en_o), 0);
    chk("R1 gie", 32'(gie_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 pc_load", 32'(pc_load_o), 0);

    // R2 sync latency and sticky pending
    src_i[3] = 1'b1;
    step(2);
    chk("R2 not yet pending", 32'(pend_o[3]), 0);
    step(1);
    chk("R2 pending after e2", 32'(pend_o[3]), 1);
    wr(2'd0, 8'hFF);
    chk("R2 write one keeps", 32'(pend_o), 32'h08);
    wr(2'd0, 8'hF7);
    chk("R2 write zero clears", 32'(pend_o), 0);
    src_i[3] = 1'b0;
    step(3);
    src_i[3] = 1'b1;
    step(2);
    wr(2'd0, 8'h00);
    chk("R2 set beats clear", 32'(pend_o[3]), 1);

    // R10 register selects
    wr(2'd1, 8'h24);
    wr(2'd3, 8'hFF);
    chk("R10 sel3 no effect en", 32'(en_o), 32'h24);
    chk("R10 sel3 no effect gie", 32'(gie_o), 0);
    chk("R10 sel3 no effect pend", 32'(pend_o), 32'h08);

    // R3 no acknowledge with gie low
    wr(2'd1, 8'h08);
    boundary(1'b0, 16'h0100);
    chk("R3 gie low no ack", 32'(busy_o), 0);
    wr(2'd2, 8'h01);

    // R5 skipped boundary; R7 pre-pending source taken
    boundary(1'b1, 16'h0200);
    chk("R5 skip no ack", 32'(busy_o), 0);
    push_ready_i = 1'b0;
    boundary(1'b0, 16'h1234);
    chk("R7 ack taken", 32'(busy_o), 1);
    chk("R4 gie cleared", 32'(gie_o), 0);
    chk("R4 push valid", 32'(push_valid_o), 1);
    chk("R4 push data", 32'(push_data_o), 32'h1234);
    step(2);
    chk("R4 push held", 32'(push_data_o), 32'h1234);
    chk("R4 no early load", 32'(pc_load_o), 0);
    push_ready_i = 1'b1;
    step(1);
    step(5);
    chk("R4 pc load cycle7", 32'(pc_load_o), 1);
    chk("R4 svc addr", 32'(pc_load_addr_o), 32'h00FF);
    step(1);
    chk("R4 done busy", 32'(busy_o), 1);
    step(1);
    chk("R4 idle after done", 32'(busy_o), 0);

    // R6 return with a second source waiting
    wr(2'd0, 8'hF7);
    wr(2'd1, 8'h0C);
    src_i[2] = 1'b1;
    step(3);
    reti_i = 1'b1;
    step(1);
    reti_i = 1'b0;
    step(1);
    chk("R6 pop ready", 32'(pop_ready_o), 1);
    chk("R6 no load before pop", 32'(pc_load_o), 0);
    pop_valid_i = 1'b1; pop_data_i = 16'h1235;
    #1;
    chk("R6 load popped", 32'(pc_load_o), 1);
    chk("R6 popped addr", 32'(pc_load_addr_o), 32'h1235);
    step(1);
    pop_valid_i = 1'b0;
    chk("R6 gie restored", 32'(gie_o), 1);
    boundary(1'b0, 16'h1235);
    chk("R6 next taken", 32'(busy_o), 1);
    step(9);

    // R9 vector select
    wr(2'd0, 8'h00);
    src_i = '0;
    step(3);
    src_i = 8'h26;
    step(4);
    wr(2'd1, 8'h24);
    vis_req_i = 1'b1;
    step(1);
    vis_req_i = 1'b0;
    chk("R9 hit", 32'(vis_hit_o), 1);
    chk("R9 priority idx", 32'(vis_idx_o), 2);
    wr(2'd1, 8'h01);
    vis_req_i = 1'b1;
    step(1);
    vis_req_i = 1'b0;
    chk("R9 none hit", 32'(vis_hit_o), 0);
    chk("R9 none idx", 32'(vis_idx_o), 0);

    // R8 boot mode
    wr(2'd0, 8'h00);
    src_i = '0;
    step(3);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h01);
    boot_mode_i = 1'b1;
    src_i[4] = 1'b1;
    step(4);
    boundary(1'b0, 16'h0400);
    chk("R8 no ack in boot", 32'(busy_o), 0);
    chk("R8 gie kept", 32'(gie_o), 1);
    src_i[4] = 1'b0;
    step(3);
    src_i[4] = 1'b1;
    step(4);
    chk("R8 repeat lost", 32'(pend_o), 32'h10);
    boot_mode_i = 1'b0;
    boundary(1'b0, 16'h0404);
    chk("R8 ack after boot", 32'(busy_o), 1);
    step(10);
    summary();
  end
endmodule